// File: doc/BRIEF.md
# Consumer-Electronics Control Header Address Filter

This block sits behind the bit-level receiver of a CEC node and judges the first byte of every incoming message. That byte names the sender in its upper nibble and the target in its lower nibble. From the target, the node's set of claimed logical addresses and the listen mode, the filter decides two things. The first is whether the message enters the receive path. The second is whether this node may drive a positive acknowledge for it.

A node can claim several logical addresses at once through a one-hot map with fifteen bits, and a map of all zeros claims none. Target 15 is the broadcast address. It has no bit in the map, and a broadcast is always let through. In reduced listen mode the filter drops unicast traffic for other nodes. In full listen mode it lets that traffic through but never acknowledges it, so the node can watch the bus without disturbing it. All results are registered one cycle after the header strobe and hold until the next header.

Top module: `cec_hdr_filter`

## Requirements
- R1: While reset is asserted, and after its release until the first header strobe, accept, ack_en and bcast are 0 and both decoded address outputs are 0.
- R2: One cycle after a cycle with hdr_valid high, init_addr equals hdr_byte[7:4] and dest_addr equals hdr_byte[3:0] as sampled in the strobe cycle.
- R3: If the sampled target d is below 15 and own_map[d] is 1, then one cycle later accept=1, ack_en=1 and bcast=0, in either listen mode.
- R4: With full_listen=0 (reduced mode), a target below 15 whose own_map bit is 0 gives accept=0 and ack_en=0 one cycle later.
- R5: With full_listen=1 (full mode), a target below 15 whose own_map bit is 0 gives accept=1 and ack_en=0 one cycle later.
- R6: Target 15 gives bcast=1, accept=1 and ack_en=0 one cycle later, in both modes and for every own_map value, including all ones.
- R7: With own_map all zero, no unicast target produces ack_en=1.
- R8: In cycles with hdr_valid low, all five outputs keep their values, whatever hdr_byte, own_map and full_listen do.
- R9: own_map and full_listen are used as sampled in the strobe cycle. Headers strobed in consecutive cycles each get their own decision, one cycle after their own strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hdr_valid | input | 1 | Header byte is present this cycle |
| hdr_byte | input | 8 | Header byte: sender in [7:4], target in [3:0] |
| own_map | input | 15 | One-hot map of claimed logical addresses, bit i claims address i |
| full_listen | input | 1 | 1 = full listen mode, 0 = reduced listen mode |
| accept | output | 1 | Message enters the receive path |
| ack_en | output | 1 | This node may acknowledge the message |
| bcast | output | 1 | Message is a broadcast |
| init_addr | output | 4 | Decoded sender address |
| dest_addr | output | 4 | Decoded target address |

## Verification
Two things can fall in the same cycle. A header strobe can coincide with a change of own_map or full_listen. A new strobe can coincide with the registered result of the previous header appearing at the outputs. The bench provokes both by sending headers in consecutive cycles while the map and the mode change on every strobe. A behavioural model updated on each clock judges the results: every decision has to follow the configuration of its own strobe cycle and appear exactly one cycle later. Idle cycles with changing inputs between headers show that the held result does not move.

// File: rtl/cec_hdr_pkg.sv
package cec_hdr_pkg;

  // width of one logical address inside the header byte
  localparam int unsigned LA_W = 4;

  // outcome of the header judgement
  typedef enum logic [1:0] {
    DEC_DROP  = 2'd0,  // foreign unicast, reduced mode
    DEC_OWN   = 2'd1,  // claimed unicast: accept and acknowledge
    DEC_SNOOP = 2'd2,  // foreign unicast, full mode: accept silently
    DEC_BCAST = 2'd3   // broadcast: accept, acknowledge handled elsewhere
  } dec_e;

  function automatic logic dec_accept(dec_e d);
    return d != DEC_DROP;
  endfunction

  function automatic logic dec_ack(dec_e d);
    return d == DEC_OWN;
  endfunction

  function automatic logic dec_bcast(dec_e d);
    return d == DEC_BCAST;
  endfunction

endpackage

// File: rtl/cec_hdr_split.sv
module cec_hdr_split #(
  parameter int unsigned ADDR_W = cec_hdr_pkg::LA_W
) (
  input  logic [2*ADDR_W-1:0] hdr,
  output logic [ADDR_W-1:0]   src,
  output logic [ADDR_W-1:0]   dst,
  output logic                dst_is_bcast
);
  // upper half names the sender, lower half the target
  assign src          = hdr[2*ADDR_W-1:ADDR_W];
  assign dst          = hdr[ADDR_W-1:0];
  // the all-ones address is reserved for broadcast
  assign dst_is_bcast = &dst;
endmodule

// File: rtl/cec_own_match.sv
module cec_own_match #(
  parameter int unsigned ADDR_W = cec_hdr_pkg::LA_W,
  localparam int unsigned NUM_LA = (1 << ADDR_W) - 1
) (
  input  logic [NUM_LA-1:0] own_map,
  input  logic [ADDR_W-1:0] dst,
  output logic [NUM_LA-1:0] hit_vec,
  output logic              hit
);
  // one comparator per claimable address; the broadcast code has no slot
  for (genvar i = 0; i < NUM_LA; i++) begin : g_slot
    assign hit_vec[i] = own_map[i] && (dst == ADDR_W'(i));
  end
  assign hit = |hit_vec;
endmodule

// File: rtl/cec_hdr_policy.sv
module cec_hdr_policy
  import cec_hdr_pkg::*;
(
  input  logic dst_is_bcast,
  input  logic own_hit,
  input  logic full_listen,
  output dec_e decision
);
  always_comb begin
    if (dst_is_bcast)     decision = DEC_BCAST;
    else if (own_hit)     decision = DEC_OWN;
    else if (full_listen) decision = DEC_SNOOP;
    else                  decision = DEC_DROP;
  end
endmodule

// File: rtl/cec_hdr_filter.sv
module cec_hdr_filter
  import cec_hdr_pkg::*;
#(
  parameter int unsigned ADDR_W = LA_W,
  localparam int unsigned NUM_LA = (1 << ADDR_W) - 1,
  localparam int unsigned HDR_W  = 2 * ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hdr_valid,
  input  logic [HDR_W-1:0]  hdr_byte,
  input  logic [NUM_LA-1:0] own_map,
  input  logic              full_listen,
  output logic              accept,
  output logic              ack_en,
  output logic              bcast,
  output logic [ADDR_W-1:0] init_addr,
  output logic [ADDR_W-1:0] dest_addr
);

  // internal events, named for the assertions
  logic [ADDR_W-1:0] dec_src;
  logic [ADDR_W-1:0] dec_dst;
  logic              dst_is_bcast;
  logic [NUM_LA-1:0] hit_vec;
  logic              own_hit;
  dec_e              decision;

  cec_hdr_split #(.ADDR_W(ADDR_W)) u_split (
    .hdr          (hdr_byte),
    .src          (dec_src),
    .dst          (dec_dst),
    .dst_is_bcast (dst_is_bcast)
  );

  cec_own_match #(.ADDR_W(ADDR_W)) u_match (
    .own_map (own_map),
    .dst     (dec_dst),
    .hit_vec (hit_vec),
    .hit     (own_hit)
  );

  cec_hdr_policy u_policy (
    .dst_is_bcast (dst_is_bcast),
    .own_hit      (own_hit),
    .full_listen  (full_listen),
    .decision     (decision)
  );

  // result register: loads on the strobe, holds otherwise
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      accept    <= 1'b0;
      ack_en    <= 1'b0;
      bcast     <= 1'b0;
      init_addr <= '0;
      dest_addr <= '0;
    end else if (hdr_valid) begin
      accept    <= dec_accept(decision);
      ack_en    <= dec_ack(decision);
      bcast     <= dec_bcast(decision);
      init_addr <= dec_src;
      dest_addr <= dec_dst;
    end
  end

  // ---------------- assertions ----------------
  assert_addr_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid |=> (init_addr == $past(hdr_byte[HDR_W-1:ADDR_W])) &&
                  (dest_addr == $past(hdr_byte[ADDR_W-1:0])));

  assert_single_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  assert_own_acked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && own_hit) |=> accept && ack_en && !bcast);

  assert_reduced_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && !full_listen && !own_hit && !dst_is_bcast) |=> !accept && !ack_en);

  assert_full_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && full_listen && !own_hit && !dst_is_bcast) |=> accept && !ack_en);

  assert_bcast_no_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && (&hdr_byte[ADDR_W-1:0])) |=> bcast && accept && !ack_en);

  assert_empty_map_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && own_map == '0) |=> !ack_en);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !hdr_valid |=> $stable({accept, ack_en, bcast, init_addr, dest_addr}));

endmodule

// File: tb/tb_cec_hdr_filter.sv
module tb_cec_hdr_filter;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hdr_valid = 1'b0;
  logic [7:0]  hdr_byte = 8'h00;
  logic [14:0] own_map = 15'h0;
  logic        full_listen = 1'b0;
  logic        accept, ack_en, bcast;
  logic [3:0]  init_addr, dest_addr;

  int checks = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;  // 250 MHz

  cec_hdr_filter dut (
    .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_byte(hdr_byte),
    .own_map(own_map), .full_listen(full_listen), .accept(accept),
    .ack_en(ack_en), .bcast(bcast), .init_addr(init_addr), .dest_addr(dest_addr)
  );

  // ---------- behavioural reference ----------
  logic       e_acc, e_ack, e_bc;
  logic [3:0] e_init, e_dest;
  string      e_tag;
  bit         prev_valid;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_acc <= 0; e_ack <= 0; e_bc <= 0; e_init <= 0; e_dest <= 0;
      e_tag <= "R1"; prev_valid <= 0;
    end else begin
      prev_valid <= hdr_valid;
      if (hdr_valid) begin
        int  d;
        bit  mine;
        d    = hdr_byte % 16;
        mine = (d < 15) && (((own_map >> d) & 15'd1) != 0);
        e_init <= hdr_byte / 16;
        e_dest <= d[3:0];
        e_bc   <= (d == 15);
        e_acc  <= (d == 15) || mine || full_listen;
        e_ack  <= mine;
        if (prev_valid)         e_tag <= "R9";
        else if (d == 15)       e_tag <= "R6";
        else if (own_map == 0)  e_tag <= "R7";
        else if (mine)          e_tag <= "R3";
        else if (full_listen)   e_tag <= "R5";
        else                    e_tag <= "R4";
      end else begin
        e_tag <= (e_tag == "R1") ? "R1" : "R8";
      end
    end
  end

  // compare on every falling edge, away from the active edge
  always @(negedge clk) begin
    if (!finished) begin
      checks++;
      if ({init_addr, dest_addr} !== {e_init, e_dest}) begin
        bad++;
        $display("FAIL %s/R2 addr: got init=%h dest=%h exp init=%h dest=%h",
                 e_tag, init_addr, dest_addr, e_init, e_dest);
      end
      checks++;
      if ({accept, ack_en, bcast} !== {e_acc, e_ack, e_bc}) begin
        bad++;
        $display("FAIL %s flags: got acc=%b ack=%b bc=%b exp acc=%b ack=%b bc=%b",
                 e_tag, accept, ack_en, bcast, e_acc, e_ack, e_bc);
      end
    end
  end

  // ---------- stimulus ----------
  task automatic send(input logic [7:0] b, input logic [14:0] m, input logic f);
    @(negedge clk);
    hdr_valid = 1'b1; hdr_byte = b; own_map = m; full_listen = f;
  endtask

  // idle cycles with churning inputs (R8)
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      hdr_valid = 1'b0;
      hdr_byte = 8'(i * 37 + 5);
      own_map = 15'(i * 4099 + 3);
      full_listen = i[0];
    end
  endtask

  task automatic finish_run;
    finished = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    checks++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: explicit reset-state check
    checks++;
    if ({accept, ack_en, bcast, init_addr, dest_addr} !== 11'b0) begin
      bad++; $display("FAIL R1 reset: got %b exp 0", {accept, ack_en, bcast, init_addr, dest_addr});
    end
    @(negedge clk); rst_n = 1'b1;
    idle(3);  // R1 state persists until first header

    // R3/R4/R5/R6 with map claiming addresses 0 and 2
    for (int f = 0; f < 2; f++) begin
      send(8'h40, 15'h0005, f[0]); idle(1);  // own 0
      send(8'h51, 15'h0005, f[0]); idle(1);  // foreign 1
      send(8'h32, 15'h0005, f[0]); idle(1);  // own 2
      send(8'hAF, 15'h0005, f[0]); idle(2);  // broadcast
    end
    // R6: broadcast with every slot claimed, and R7: empty map
    send(8'h1F, 15'h7FFF, 1'b0); idle(1);
    send(8'h2E, 15'h7FFF, 1'b0); idle(1);  // address 14 claimed
    send(8'h2E, 15'h0000, 1'b1); idle(1);
    send(8'h20, 15'h0000, 1'b0); idle(1);
    send(8'h2F, 15'h0000, 1'b0); idle(1);

    // R9: back-to-back strobes with configuration changing each cycle
    send(8'h13, 15'h0008, 1'b0);
    send(8'h13, 15'h0000, 1'b0);
    send(8'h13, 15'h0000, 1'b1);
    send(8'h13, 15'h0008, 1'b1);
    send(8'h0F, 15'h0008, 1'b0);
    send(8'h07, 15'h0000, 1'b0);
    idle(4);

    // sweep of all header bytes under several maps and both modes
    for (int m = 0; m < 3; m++) begin
      for (int f = 0; f < 2; f++) begin
        for (int b = 0; b < 256; b++) begin
          send(8'(b), (m == 0) ? 15'h0000 : (m == 1) ? 15'h4A21 : 15'h7FFF, f[0]);
          if (b % 5 == 0) idle(2);
        end
      end
    end
    idle(3);
    finish_run();
  end

endmodule